// File: doc/BRIEF.md
# Quad-Precision Round and Pack Unit

This unit is the last step of a binary128 datapath. An arithmetic stage delivers an unrounded value: a sign, a signed exponent held one below the true exponent, and a wide significand. The significand has three parts. The high word holds the integer bit and the upper fraction. The middle word holds the lower fraction. The extra word collects guard and sticky information. The unit rounds the value in one of four modes and packs it into the 128-bit interchange layout. It raises overflow, underflow and inexact as needed.

Packing is an addition, not a concatenation. The sign, the shifted exponent and the significand are summed. An integer bit, or a carry out of rounding, therefore moves into the exponent field. Overflow saturates to infinity or to the largest finite magnitude, depending on the mode and the sign. A negative exponent makes the unit denormalize the significand. It does this with a sticky right shift, and tininess is judged either before or after rounding.

The result is registered. The latency is set by the `PIPE_STAGES` parameter to one or two clock cycles. With the default values of the parameters, the unit handles binary128. A smaller set of parameters gives a narrow variant of the same behaviour.

Top module: `qrp_round_pack`

## Requirements
- R1: In mode code 0 (nearest-even), the significand is incremented exactly when the most significant bit of the extra word is 1. When the remaining extra-word bits are all 0 (a tie), the least significant bit of the incremented significand is cleared.
- R2: Mode code 3 (toward zero) never increments. Mode code 1 (down) increments only when the sign is 1 and the extra word is non-zero. Mode code 2 (up) increments only when the sign is 0 and the extra word is non-zero.
- R3: Overflow is raised, together with inexact, in two cases. The first is a signed exponent above 2^EXP_W−3 (0x7FFD by default). The second is an exponent equal to that limit, with an all-ones significand and an increment decided by the mode. In no other case is overflow raised, and without overflow the exponent field is never all ones.
- R4: On overflow, the largest finite magnitude is returned in three cases: toward zero, sign 1 in mode up, and sign 0 in mode down. The largest finite magnitude has exponent field all ones minus one and an all-ones fraction. In every other case the result is infinity: exponent field all ones and fraction 0.
- R5: For a negative exponent, the whole significand is shifted right by the magnitude of the exponent. Any 1 bits shifted out are ORed into the extra word's least significant bit. The exponent becomes 0, and the increment is decided again from the shifted extra word.
- R6: For a negative exponent, the value is tiny when any of these holds: before-rounding detection is selected, the exponent is below −1, the original extra word gives no increment, or the significand is not all ones. Underflow is raised only when the value is tiny and the shifted extra word is non-zero.
- R7: Inexact is raised whenever the extra word used for the final rounding is non-zero.
- R8: When there is no increment and the significand is zero, the exponent field of the result is 0.
- R9: The result equals sign·2^127 + exponent·2^112 + significand, taken modulo 2^128. The integer bit, and any carry out of rounding, add into the exponent field.
- R10: Reset clears the result and all flags to 0. Each input set appears at the outputs exactly PIPE_STAGES clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | IN_EXP_W (32) | Signed exponent, one below the true exponent |
| in_sig_hi | input | HI_W (49) | High significand word, integer bit at the top |
| in_sig_mid | input | WORD_W (64) | Middle significand word |
| in_sig_ext | input | WORD_W (64) | Extra guard/sticky word |
| in_rnd_mode | input | 2 | 0 nearest-even, 1 down, 2 up, 3 toward zero |
| in_tiny_before | input | 1 | 1: judge tininess before rounding |
| out_result | output | RES_W (128) | Packed result |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Most properties relate only the outputs to one another, so they make no assumption about whether the significand is normalized. Two properties, the exponent-threshold overflow check and the no-overflow-for-negative-exponent check, also look at the exponent driven PIPE_STAGES cycles earlier. These two take for granted that the inputs carry known values from reset onward, and the stimulus drives every input from time zero. The sweep feeds unnormalized significands as well as normalized ones, with exponents chosen on both sides of the overflow limit, at zero, at −1 and −2, and far below the significand width. This exercises denormalization, tininess and saturation well beyond the normalized inputs an upstream stage would send.

// File: rtl/qrp_pkg.sv
package qrp_pkg;

   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'd0,
      RND_DOWN      = 2'd1,
      RND_UP        = 2'd2,
      RND_ZERO      = 2'd3
   } rnd_mode_e;

endpackage

// File: rtl/qrp_incr_decide.sv
module qrp_incr_decide
   import qrp_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic              sign_i,
   input  rnd_mode_e         mode_i,
   input  logic [WORD_W-1:0] ext_i,
   output logic              incr_o,
   output logic              tie_o
);

   logic ext_nz;

   assign ext_nz = |ext_i;
   // R1: tie when everything below the round bit is zero
   assign tie_o  = ~|ext_i[WORD_W-2:0];

   always_comb begin
      unique case (mode_i)
         RND_NEAR_EVEN: incr_o = ext_i[WORD_W-1];
         RND_DOWN:      incr_o = sign_i & ext_nz;
         RND_UP:        incr_o = ~sign_i & ext_nz;
         default:       incr_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/qrp_jam_shift.sv
module qrp_jam_shift #(
   parameter int FULL_W = 177,
   parameter int AMT_W  = 9
) (
   input  logic [FULL_W-1:0] val_i,
   input  logic [AMT_W-1:0]  amt_i,
   output logic [FULL_W-1:0] val_o
);

   logic [FULL_W-1:0] keep_mask;
   logic              lost;

   // R5: every bit that falls off the bottom folds into bit 0
   assign keep_mask = {FULL_W{1'b1}} << amt_i;
   assign lost      = |(val_i & ~keep_mask);
   assign val_o     = (val_i >> amt_i) | {{(FULL_W-1){1'b0}}, lost};

endmodule

// File: rtl/qrp_round_core.sv
module qrp_round_core
   import qrp_pkg::*;
#(
   parameter int EXP_W    = 15,
   parameter int HI_W     = 49,
   parameter int WORD_W   = 64,
   parameter int IN_EXP_W = 32,
   localparam int SIG_W   = HI_W + WORD_W,
   localparam int RES_W   = EXP_W + SIG_W
) (
   input  logic                       sign_i,
   input  logic signed [IN_EXP_W-1:0] exp_i,
   input  logic [HI_W-1:0]            hi_i,
   input  logic [WORD_W-1:0]          mid_i,
   input  logic [WORD_W-1:0]          ext_i,
   input  rnd_mode_e                  mode_i,
   input  logic                       tiny_before_i,
   output logic [RES_W-1:0]           result_o,
   output logic                       ovf_o,
   output logic                       unf_o,
   output logic                       inx_o
);

   localparam int FULL_W = SIG_W + WORD_W;
   localparam int FRAC_W = SIG_W - 1;
   localparam int AMT_W  = $clog2(FULL_W) + 1;
   localparam logic signed [IN_EXP_W-1:0] EXP_OVF   = IN_EXP_W'((2 ** EXP_W) - 3);
   localparam logic signed [IN_EXP_W-1:0] NEG_ONE   = -1;
   localparam logic [IN_EXP_W-1:0]        FULL_AMT  = IN_EXP_W'(FULL_W);
   localparam logic [EXP_W-1:0]           EXP_ALL   = {EXP_W{1'b1}};

   logic [SIG_W-1:0]    sig_in;
   logic                incr_pre, tie_pre;
   logic                ovf_big, ovf_edge, ovf;
   logic                neg_exp, tiny;
   logic [IN_EXP_W-1:0] neg_amt;
   logic [AMT_W-1:0]    amt;
   logic [FULL_W-1:0]   shifted;
   logic [SIG_W-1:0]    sig_w;
   logic [WORD_W-1:0]   ext_w;
   logic [EXP_W-1:0]    exp_w, exp_fin;
   logic                incr_w, tie_w;
   logic [SIG_W:0]      sum, sig_fin;
   logic                pick_max;
   logic [RES_W-1:0]    packed_val, sat_val;

   assign sig_in = {hi_i, mid_i};

   qrp_incr_decide #(.WORD_W(WORD_W)) pre_dec_i (
      .sign_i (sign_i),
      .mode_i (mode_i),
      .ext_i  (ext_i),
      .incr_o (incr_pre),
      .tie_o  (tie_pre)
   );

   // R3: signed compare, so negative exponents never count as large
   assign ovf_big  = exp_i > EXP_OVF;
   assign ovf_edge = (exp_i == EXP_OVF) && (&sig_in) && incr_pre;
   assign ovf      = ovf_big | ovf_edge;

   // R6: tininess is judged on the unshifted value
   assign neg_exp = exp_i[IN_EXP_W-1];
   assign tiny    = tiny_before_i | (exp_i < NEG_ONE) | ~incr_pre | ~(&sig_in);

   assign neg_amt = IN_EXP_W'(-exp_i);
   assign amt     = (neg_amt > FULL_AMT) ? AMT_W'(FULL_W) : neg_amt[AMT_W-1:0];

   qrp_jam_shift #(.FULL_W(FULL_W), .AMT_W(AMT_W)) denorm_i (
      .val_i (({sig_in, ext_i})),
      .amt_i (amt),
      .val_o (shifted)
   );

   // R5: after denormalization the exponent becomes zero
   assign sig_w = neg_exp ? shifted[FULL_W-1:WORD_W] : sig_in;
   assign ext_w = neg_exp ? shifted[WORD_W-1:0]      : ext_i;
   assign exp_w = neg_exp ? '0 : exp_i[EXP_W-1:0];

   qrp_incr_decide #(.WORD_W(WORD_W)) fin_dec_i (
      .sign_i (sign_i),
      .mode_i (mode_i),
      .ext_i  (ext_w),
      .incr_o (incr_w),
      .tie_o  (tie_w)
   );

   // R1: nearest-even tie clears the result LSB
   assign sum = {1'b0, sig_w} + (SIG_W+1)'(1);

   always_comb begin
      if (incr_w) begin
         sig_fin = sum;
         if (mode_i == RND_NEAR_EVEN && tie_w) sig_fin[0] = 1'b0;
      end else begin
         sig_fin = {1'b0, sig_w};
      end
   end

   // R8: zero significand without increment forces a zero exponent
   assign exp_fin = (!incr_w && sig_w == '0) ? '0 : exp_w;

   // R9: fields are summed so carries reach the exponent
   assign packed_val = {sign_i, {(RES_W-1){1'b0}}}
                     + ({{(RES_W-EXP_W){1'b0}}, exp_fin} << FRAC_W)
                     + {{(RES_W-SIG_W-1){1'b0}}, sig_fin};

   // R4: saturation target per mode and sign
   assign pick_max = (mode_i == RND_ZERO)
                   | (sign_i & (mode_i == RND_UP))
                   | (~sign_i & (mode_i == RND_DOWN));
   assign sat_val  = pick_max ? {sign_i, EXP_ALL - EXP_W'(1), {FRAC_W{1'b1}}}
                              : {sign_i, EXP_ALL, {FRAC_W{1'b0}}};

   assign result_o = ovf ? sat_val : packed_val;
   assign ovf_o    = ovf;
   // R6 / R7
   assign unf_o    = ~ovf & neg_exp & tiny & (|ext_w);
   assign inx_o    = ovf | (|ext_w);

   logic unused_pre_tie;
   assign unused_pre_tie = tie_pre;

endmodule

// File: rtl/qrp_round_pack.sv
module qrp_round_pack
   import qrp_pkg::*;
#(
   parameter int EXP_W       = 15,
   parameter int HI_W        = 49,
   parameter int WORD_W      = 64,
   parameter int IN_EXP_W    = 32,
   parameter int PIPE_STAGES = 1,
   localparam int RES_W      = EXP_W + HI_W + WORD_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_sign,
   input  logic signed [IN_EXP_W-1:0] in_exp,
   input  logic [HI_W-1:0]            in_sig_hi,
   input  logic [WORD_W-1:0]          in_sig_mid,
   input  logic [WORD_W-1:0]          in_sig_ext,
   input  logic [1:0]                 in_rnd_mode,
   input  logic                       in_tiny_before,
   output logic [RES_W-1:0]           out_result,
   output logic                       out_overflow,
   output logic                       out_underflow,
   output logic                       out_inexact
);

   generate
      if (PIPE_STAGES < 1 || PIPE_STAGES > 2) begin : g_bad_pipe
         $error("qrp_round_pack: PIPE_STAGES must be 1 or 2");
      end
      if (HI_W < 2 || WORD_W < 2) begin : g_bad_words
         $error("qrp_round_pack: significand words too narrow");
      end
      if (EXP_W < 3 || IN_EXP_W < EXP_W + 2) begin : g_bad_exp
         $error("qrp_round_pack: exponent widths inconsistent");
      end
   endgenerate

   logic                       c_sign, c_tiny;
   logic signed [IN_EXP_W-1:0] c_exp;
   logic [HI_W-1:0]            c_hi;
   logic [WORD_W-1:0]          c_mid, c_ext;
   logic [1:0]                 c_mode;

   generate
      if (PIPE_STAGES == 2) begin : g_in_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c_sign <= 1'b0;
               c_exp  <= '0;
               c_hi   <= '0;
               c_mid  <= '0;
               c_ext  <= '0;
               c_mode <= '0;
               c_tiny <= 1'b0;
            end else begin
               c_sign <= in_sign;
               c_exp  <= in_exp;
               c_hi   <= in_sig_hi;
               c_mid  <= in_sig_mid;
               c_ext  <= in_sig_ext;
               c_mode <= in_rnd_mode;
               c_tiny <= in_tiny_before;
            end
         end
      end else begin : g_in_pass
         assign c_sign = in_sign;
         assign c_exp  = in_exp;
         assign c_hi   = in_sig_hi;
         assign c_mid  = in_sig_mid;
         assign c_ext  = in_sig_ext;
         assign c_mode = in_rnd_mode;
         assign c_tiny = in_tiny_before;
      end
   endgenerate

   logic [RES_W-1:0] core_res;
   logic             core_ovf, core_unf, core_inx;

   qrp_round_core #(
      .EXP_W    (EXP_W),
      .HI_W     (HI_W),
      .WORD_W   (WORD_W),
      .IN_EXP_W (IN_EXP_W)
   ) core_i (
      .sign_i        (c_sign),
      .exp_i         (c_exp),
      .hi_i          (c_hi),
      .mid_i         (c_mid),
      .ext_i         (c_ext),
      .mode_i        (rnd_mode_e'(c_mode)),
      .tiny_before_i (c_tiny),
      .result_o      (core_res),
      .ovf_o         (core_ovf),
      .unf_o         (core_unf),
      .inx_o         (core_inx)
   );

   // R10: output stage, cleared by reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_result    <= '0;
         out_overflow  <= 1'b0;
         out_underflow <= 1'b0;
         out_inexact   <= 1'b0;
      end else begin
         out_result    <= core_res;
         out_overflow  <= core_ovf;
         out_underflow <= core_unf;
         out_inexact   <= core_inx;
      end
   end

endmodule

// File: rtl/qrp_round_pack_chk.sv
module qrp_round_pack_chk #(
   parameter int EXP_W       = 15,
   parameter int HI_W        = 49,
   parameter int WORD_W      = 64,
   parameter int IN_EXP_W    = 32,
   parameter int PIPE_STAGES = 1,
   localparam int RES_W      = EXP_W + HI_W + WORD_W
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic signed [IN_EXP_W-1:0] in_exp,
   input logic [RES_W-1:0]           out_result,
   input logic                       out_overflow,
   input logic                       out_underflow,
   input logic                       out_inexact
);

   localparam int FRAC_W = HI_W + WORD_W - 1;
   localparam logic signed [IN_EXP_W-1:0] EXP_OVF = IN_EXP_W'((2 ** EXP_W) - 3);
   localparam logic [EXP_W-1:0] EXP_ALL = {EXP_W{1'b1}};

   logic [1:0]       cyc;
   logic [EXP_W-1:0] res_exp;
   logic [FRAC_W-1:0] res_frac;

   assign res_exp  = out_result[RES_W-2 -: EXP_W];
   assign res_frac = out_result[FRAC_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)          cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   assert_ovf_inexact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> out_inexact);

   assert_noovf_not_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !out_overflow |-> (res_exp != EXP_ALL));

   assert_big_exp_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc >= 2'(PIPE_STAGES)) && ($past(in_exp, PIPE_STAGES) > EXP_OVF)) |-> out_overflow);

   assert_ovf_top_exp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_overflow |-> (res_exp >= EXP_ALL - EXP_W'(1)));

   assert_inf_zero_frac_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_overflow && res_exp == EXP_ALL) |-> (res_frac == '0));

   assert_neg_exp_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((cyc >= 2'(PIPE_STAGES)) && ($past(in_exp, PIPE_STAGES) < 0)) |-> !out_overflow);

   assert_unf_small_exp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_underflow |-> (res_exp <= EXP_W'(1)));

   assert_unf_inexact_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_underflow |-> (out_inexact && !out_overflow));

endmodule

bind qrp_round_pack qrp_round_pack_chk #(
   .EXP_W       (EXP_W),
   .HI_W        (HI_W),
   .WORD_W      (WORD_W),
   .IN_EXP_W    (IN_EXP_W),
   .PIPE_STAGES (PIPE_STAGES)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_exp        (in_exp),
   .out_result    (out_result),
   .out_overflow  (out_overflow),
   .out_underflow (out_underflow),
   .out_inexact   (out_inexact)
);

// File: tb/qrp_round_pack_tb_top.sv
module qrp_round_pack_tb_top;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n;
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   // binary128 instance, one stage
   logic               q_sign, q_tb;
   logic signed [31:0] q_exp;
   logic [48:0]        q_hi;
   logic [63:0]        q_mid, q_ext;
   logic [1:0]         q_mode;
   logic [127:0]       q_res;
   logic               q_ov, q_un, q_ix;

   qrp_round_pack dut_i (
      .clk (clk), .rst_n (rst_n),
      .in_sign (q_sign), .in_exp (q_exp), .in_sig_hi (q_hi),
      .in_sig_mid (q_mid), .in_sig_ext (q_ext), .in_rnd_mode (q_mode),
      .in_tiny_before (q_tb),
      .out_result (q_res), .out_overflow (q_ov),
      .out_underflow (q_un), .out_inexact (q_ix)
   );

   // narrow instance, two stages: exp 5 bits, words 3/4/4
   logic              s_sign, s_tb;
   logic signed [7:0] s_exp;
   logic [2:0]        s_hi;
   logic [3:0]        s_mid, s_ext;
   logic [1:0]        s_mode;
   logic [11:0]       s_res;
   logic              s_ov, s_un, s_ix;

   qrp_round_pack #(
      .EXP_W (5), .HI_W (3), .WORD_W (4), .IN_EXP_W (8), .PIPE_STAGES (2)
   ) sweep_i (
      .clk (clk), .rst_n (rst_n),
      .in_sign (s_sign), .in_exp (s_exp), .in_sig_hi (s_hi),
      .in_sig_mid (s_mid), .in_sig_ext (s_ext), .in_rnd_mode (s_mode),
      .in_tiny_before (s_tb),
      .out_result (s_res), .out_overflow (s_ov),
      .out_underflow (s_un), .out_inexact (s_ix)
   );

   task automatic check(input string tag, input logic [130:0] act, input logic [130:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic bit inc_of(bit s, bit [3:0] x, bit [1:0] md);
      case (md)
         2'd0:    return x[3];
         2'd1:    return s && (x != 0);
         2'd2:    return !s && (x != 0);
         default: return 1'b0;
      endcase
   endfunction

   // reference for the narrow variant: {res[11:0], ov, un, ix}
   function automatic bit [14:0] model(bit s, int e, bit [2:0] hi, bit [3:0] mid,
                                       bit [3:0] ext, bit [1:0] md, bit tb);
      int  sig, v, ee, sig2, ext2, res;
      bit  inc0, inc, tiny, lost, maxf, un, ix;
      sig  = int'({hi, mid});
      inc0 = inc_of(s, ext, md);
      if (e > 29 || (e == 29 && sig == 127 && inc0)) begin
         maxf = (md == 3) || (s && md == 2) || (!s && md == 1);
         res  = (s ? 2048 : 0) + (maxf ? (30 * 64 + 63) : (31 * 64));
         return {res[11:0], 1'b1, 1'b0, 1'b1};
      end
      v    = int'({hi, mid, ext});
      ee   = e;
      tiny = 1'b0;
      if (e < 0) begin
         tiny = tb || (e < -1) || !inc0 || (sig != 127);
         lost = 1'b0;
         for (int k = 0; k < -e && k < 40; k++) begin
            lost = lost | v[0];
            v    = v >> 1;
         end
         v  = v | int'(lost);
         ee = 0;
      end
      ext2 = v & 15;
      sig2 = v >> 4;
      inc  = inc_of(s, ext2[3:0], md);
      if (inc) begin
         sig2 = sig2 + 1;
         if (md == 0 && (ext2 & 7) == 0) sig2 = sig2 & ~1;
      end else if (sig2 == 0) begin
         ee = 0;
      end
      ix  = (ext2 != 0);
      un  = (e < 0) && tiny && ix;
      res = ((s ? 2048 : 0) + ee * 64 + sig2) & 4095;
      return {res[11:0], 1'b0, un, ix};
   endfunction

   function automatic string tag_of(bit [14:0] expv, bit [14:0] act, int e, bit [1:0] md);
      if (expv[14:3] != act[14:3]) begin
         if (expv[2])        return "R4 result";
         else if (e < 0)     return "R5 result";
         else if (expv[8:3] == 0) return "R8 result";
         else if (md == 0)   return "R1 result";
         else                return "R2 result";
      end
      if (expv[2] != act[2]) return "R3 overflow flag";
      if (expv[1] != act[1]) return "R6 underflow flag";
      return "R7 inexact flag";
   endfunction

   task automatic q_drive(bit s, logic signed [31:0] e, logic [48:0] hi, logic [63:0] mid,
                          logic [63:0] ext, logic [1:0] md, bit tb);
      @(negedge clk);
      q_sign = s; q_exp = e; q_hi = hi; q_mid = mid; q_ext = ext; q_mode = md; q_tb = tb;
      @(negedge clk);
   endtask

   int exp_list [13] = '{-128, -12, -11, -3, -2, -1, 0, 1, 14, 28, 29, 30, 127};

   initial begin
      bit [14:0] h0, h1, act;
      int        e0, e1;
      bit [1:0]  m0, m1;
      int        fill;
      rst_n = 1'b0;
      q_sign = 0; q_exp = 0; q_hi = 0; q_mid = 0; q_ext = 0; q_mode = 0; q_tb = 0;
      s_sign = 0; s_exp = 0; s_hi = 0; s_mid = 0; s_ext = 0; s_mode = 0; s_tb = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 reset quad", {q_res, q_ov, q_un, q_ix}, '0);
      check("R10 reset narrow", {119'd0, s_res, s_ov, s_un, s_ix}, '0);
      rst_n = 1'b1;

      // R9: integer bit carries into exponent, value 1.0
      q_drive(0, 32'sh3FFE, 49'h1_0000_0000_0000, 0, 0, 2'd0, 0);
      check("R9 one", {q_res, q_ov, q_un, q_ix},
            {128'h3FFF0000000000000000000000000000, 3'b000});
      // R3/R4: huge exponent, nearest-even -> infinity
      q_drive(0, 32'sh7FFF, 49'h1_0000_0000_0000, 0, 0, 2'd0, 0);
      check("R4 infinity", {q_res, q_ov, q_un, q_ix},
            {128'h7FFF0000000000000000000000000000, 3'b101});
      // R4: toward zero -> largest finite
      q_drive(0, 32'sh7FFF, 49'h1_0000_0000_0000, 0, 0, 2'd3, 0);
      check("R4 max finite", {q_res, q_ov, q_un, q_ix},
            {128'h7FFEFFFFFFFFFFFFFFFFFFFFFFFFFFFF, 3'b101});
      // R9: rounding carry out of an all-ones significand
      q_drive(0, 32'sh7FFC, 49'h1_FFFF_FFFF_FFFF, 64'hFFFFFFFFFFFFFFFF,
              64'h8000000000000000, 2'd0, 0);
      check("R9 carry", {q_res, q_ov, q_un, q_ix},
            {128'h7FFE0000000000000000000000000000, 3'b001});
      // R5: exponent -1, exact shift, no underflow
      q_drive(0, -32'sd1, 49'h1_0000_0000_0000, 0, 0, 2'd0, 1);
      check("R5 exact denorm", {q_res, q_ov, q_un, q_ix},
            {128'h00008000000000000000000000000000, 3'b000});
      // R8: zero significand, large exponent
      q_drive(1, 32'sd100, 0, 0, 0, 2'd0, 0);
      check("R8 zero", {q_res, q_ov, q_un, q_ix},
            {128'h80000000000000000000000000000000, 3'b000});
      // R2: up mode on a negative value does not increment
      q_drive(1, 32'sh3FFE, 49'h1_0000_0000_0000, 0, 64'd1, 2'd2, 0);
      check("R2 up negative", {q_res, q_ov, q_un, q_ix},
            {128'hBFFF0000000000000000000000000000, 3'b001});

      // narrow sweep, two-cycle latency (R10), all requirements
      fill = 0; h0 = 0; h1 = 0; e0 = 0; e1 = 0; m0 = 0; m1 = 0;
      foreach (exp_list[ei]) begin
         for (int ctl = 0; ctl < 16; ctl++) begin
            for (int hi = 0; hi < 8; hi++) begin
               for (int mi = 0; mi < 4; mi++) begin
                  for (int ex = 0; ex < 16; ex++) begin
                     bit [3:0] midv;
                     midv = (mi == 0) ? 4'd0 : (mi == 1) ? 4'd1 : (mi == 2) ? 4'd8 : 4'd15;
                     @(negedge clk);
                     if (fill >= 2) begin
                        act = {s_res, s_ov, s_un, s_ix};
                        if (act !== h1) check(tag_of(h1, act, e1, m1), {116'd0, act}, {116'd0, h1});
                        else check("R10 sweep", {116'd0, act}, {116'd0, h1});
                     end
                     s_sign = ctl[0]; s_tb = ctl[1]; s_mode = 2'(ctl >> 2);
                     s_exp = 8'(exp_list[ei]); s_hi = 3'(hi); s_mid = midv; s_ext = 4'(ex);
                     h1 = h0; e1 = e0; m1 = m0;
                     h0 = model(ctl[0], exp_list[ei], 3'(hi), midv, 4'(ex), 2'(ctl >> 2), ctl[1]);
                     e0 = exp_list[ei]; m0 = 2'(ctl >> 2);
                     fill++;
                  end
               end
            end
         end
      end
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         act = {s_res, s_ov, s_un, s_ix};
         if (act !== h1) check(tag_of(h1, act, e1, m1), {116'd0, act}, {116'd0, h1});
         else check("R10 sweep", {116'd0, act}, {116'd0, h1});
         h1 = h0; e1 = e0; m1 = m0;
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 190000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule